// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns one asynchronous external interrupt pin into a clean interrupt request. The pin passes through a synchroniser and then a programmable noise filter. A filtered level is accepted only when several consecutive samples agree, and the sampling rate is selectable. An edge detector follows the filter. It fires on one chosen edge, or on both edges of the filtered level. A qualified edge sets a sticky request flag, which software clears with a strobe. The same qualified edge leaves the block as a one-cycle trigger strobe, so a timer that shares the pin can use it.

Software programs the block through two byte-wide registers. The control register holds the input-enable and both-edges bits. The filter register holds the sampling-rate selector. The edge direction used in single-edge mode arrives as a separate input, driven by a bit held in the interrupt-control logic outside this block. Turning the both-edges bit on or off while the input is enabled sets the request flag. Software clears the flag after any such change.

Top module: `extint_conditioner`

## Requirements
- R1: While the enable bit (bit 0 of the control register, `wr_sel`/`rd_sel` = 0) is 0, pin activity never pulses `trig_o` and never sets `irq_flag_o`.
- R2: With the both-edges bit (bit 1 of the control register) at 0, only the edge picked by `edge_pol_i` is qualified: 0 picks high-to-low, 1 picks low-to-high.
- R3: With the both-edges bit at 1, every change of the filtered level is qualified. `edge_pol_i` is held at 0 in this mode.
- R4: The filter register (`wr_sel`/`rd_sel` = 1), bits 1:0, selects the mode. 00 bypasses the filter. 01 samples every clock. 10 samples once every 8 clocks. 11 samples once every 32 clocks, with the sampling points set by a free-running prescaler.
- R5: In the filtered modes, a new level is accepted only on a sample where it and the two samples before it agree. A pulse that covers fewer than three sample points is rejected.
- R6: `irq_flag_o` is set by a qualified edge and stays set until `clr_i` is high at a clock edge. When a set and a clear meet in the same cycle, the flag ends set.
- R7: A control-register write with bit 0 = 1 that changes the both-edges bit sets `irq_flag_o` in the same cycle. A write that leaves the bit unchanged, or that has bit 0 = 0, does not set it.
- R8: `trig_o` is high for exactly the cycles in which a qualified edge is present, and each of those cycles sets the flag at the next clock edge.
- R9: After reset both registers read 0. Bits 7:2 of either register read as 0 whatever was written to them.
- R10: The pin passes through two synchroniser flops. In bypass mode, a pin change driven after clock edge k gives `trig_o` high after edge k+2 and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (base sampling clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw external interrupt pin |
| edge_pol_i | input | 1 | Single-edge direction: 0 falling, 1 rising |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 filter |
| wr_data | input | 8 | Write data byte |
| rd_sel | input | 1 | Read target: 0 control, 1 filter |
| rd_data | output | 8 | Read data byte |
| clr_i | input | 1 | Request-flag clear strobe |
| irq_flag_o | output | 1 | Sticky interrupt request |
| trig_o | output | 1 | Qualified edge strobe for a shared timer trigger |

## Verification
The assertions assume that `edge_pol_i` stays 0 whenever the input is enabled in both-edges mode. The stimulus changes that input only while the both-edges bit is 0. The filter-hold and flag-stickiness properties assume the prescaler and the filter history start from reset, so every run begins with a reset pulse. Glitch widths for each filter mode are chosen to cover two sample points at most, whatever their phase against the prescaler. Long pulses cover many more than three.

// File: rtl/extint_pkg.sv
package extint_pkg;
   typedef enum logic [1:0] {
      FILT_NONE = 2'b00,
      FILT_F1   = 2'b01,
      FILT_F8   = 2'b10,
      FILT_F32  = 2'b11
   } filt_sel_e;

   typedef struct packed {
      logic both;
      logic en;
   } ctl_t;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("extint_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= '0;
      else        ff_q <= {ff_q[STAGES-2:0], d};
   end

   assign q = ff_q[STAGES-1];
endmodule

// File: rtl/extint_filter.sv
module extint_filter
   import extint_pkg::*;
#(
   parameter int AGREE    = 3,
   parameter int DIV_MID  = 8,
   parameter int DIV_SLOW = 32
) (
   input  logic      clk,
   input  logic      rst_n,
   input  filt_sel_e sel,
   input  logic      din,
   output logic      dout
);
   localparam int CNT_W = $clog2(DIV_SLOW);
   localparam int MID_W = $clog2(DIV_MID);

   if (AGREE < 2) begin : g_bad_agree
      $error("extint_filter: AGREE must be at least 2");
   end
   if (DIV_MID < 2 || (1 << MID_W) != DIV_MID) begin : g_bad_mid
      $error("extint_filter: DIV_MID must be a power of two >= 2");
   end
   if (DIV_SLOW <= DIV_MID || (1 << CNT_W) != DIV_SLOW) begin : g_bad_slow
      $error("extint_filter: DIV_SLOW must be a power of two above DIV_MID");
   end

   logic [CNT_W-1:0] pre_q;
   logic             samp;
   logic [AGREE-2:0] hist_q;
   logic [AGREE-1:0] window;
   logic             filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   always_comb begin
      case (sel)
         FILT_F8:  samp = &pre_q[MID_W-1:0];
         FILT_F32: samp = &pre_q;
         default:  samp = 1'b1;
      endcase
   end

   assign window = {hist_q, din};

   if (AGREE == 2) begin : g_hist_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    hist_q <= '0;
         else if (samp) hist_q <= din;
      end
   end else begin : g_hist_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    hist_q <= '0;
         else if (samp) hist_q <= {hist_q[AGREE-3:0], din};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  filt_q <= 1'b0;
      else if (samp && &window)    filt_q <= 1'b1;
      else if (samp && ~|window)   filt_q <= 1'b0;
   end

   assign dout = (sel == FILT_NONE) ? din : filt_q;

   // R5: the accepted level moves only on a sampling point
   a_r5_hold_between_samples : assert property (@(posedge clk) disable iff (!rst_n)
      !samp |=> $stable(filt_q));
   // R5: a change of accepted level always follows agreement with the input
   a_r5_change_needs_input : assert property (@(posedge clk) disable iff (!rst_n)
      (samp && (din != filt_q) && (hist_q[0] != din)) |=> $stable(filt_q));
endmodule

// File: rtl/extint_edge.sv
module extint_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic en,
   input  logic both,
   input  logic pol,
   input  logic clr,
   input  logic mode_set,
   output logic trig_o,
   output logic flag_o
);
   logic prev_q;
   logic rise;
   logic fall;
   logic hit;
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

   always_comb begin
      if (both)     hit = rise | fall;
      else if (pol) hit = rise;
      else          hit = fall;
   end

   assign trig_o = en & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   flag_q <= 1'b0;
      else if (trig_o || mode_set)  flag_q <= 1'b1;
      else if (clr)                 flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // R6: sticky until cleared
   a_r6_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q);
   // R6 / R8: a qualified edge wins over a simultaneous clear
   a_r8_trig_sets_flag : assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> flag_q);
   // R1: disabled input cannot raise the request
   a_r1_disabled_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !mode_set && !flag_q) |=> !flag_q);
   // R3: direction input must be 0 in both-edges mode
   a_r3_pol_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (en && both) |-> !pol);
endmodule

// File: rtl/extint_conditioner.sv
module extint_conditioner
   import extint_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int AGREE       = 3,
   parameter int DIV_MID     = 8,
   parameter int DIV_SLOW    = 32,
   parameter int REG_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_i,
   input  logic             edge_pol_i,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic             rd_sel,
   output logic [REG_W-1:0] rd_data,
   input  logic             clr_i,
   output logic             irq_flag_o,
   output logic             trig_o
);
   localparam int CTL_W  = $bits(ctl_t);
   localparam int FSEL_W = $bits(filt_sel_e);

   if (REG_W < CTL_W || REG_W < FSEL_W) begin : g_bad_reg
      $error("extint_conditioner: REG_W too narrow for the fields");
   end

   ctl_t      ctl_q;
   filt_sel_e fsel_q;
   logic      pin_sync;
   logic      lvl;
   logic      mode_set;
   logic      wr_ctl;
   logic      wr_flt;
   logic      wr_unused;

   assign wr_ctl    = wr_en & ~wr_sel;
   assign wr_flt    = wr_en & wr_sel;
   assign wr_unused = &{1'b0, wr_data[REG_W-1:CTL_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         fsel_q <= FILT_NONE;
      end else begin
         if (wr_ctl) ctl_q  <= ctl_t'(wr_data[CTL_W-1:0]);
         if (wr_flt) fsel_q <= filt_sel_e'(wr_data[FSEL_W-1:0]);
      end
   end

   assign mode_set = wr_ctl & wr_data[0] & (wr_data[1] ^ ctl_q.both);

   always_comb begin
      rd_data = '0;
      if (rd_sel) rd_data[FSEL_W-1:0] = fsel_q;
      else        rd_data[CTL_W-1:0]  = ctl_q;
   end

   extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_i),
      .q     (pin_sync)
   );

   extint_filter #(.AGREE(AGREE), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (fsel_q),
      .din   (pin_sync),
      .dout  (lvl)
   );

   extint_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl),
      .en       (ctl_q.en),
      .both     (ctl_q.both),
      .pol      (edge_pol_i),
      .clr      (clr_i),
      .mode_set (mode_set),
      .trig_o   (trig_o),
      .flag_o   (irq_flag_o)
   );

   // R7: changing the edge mode while enabled raises the request
   a_r7_mode_rewrite : assert property (@(posedge clk) disable iff (!rst_n)
      mode_set |=> irq_flag_o);
   // R9: a write to one register leaves the other unchanged
   a_r9_ctl_kept : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctl |=> $stable(ctl_q));
endmodule

// File: tb/tb_extint_conditioner.sv
module tb_extint_conditioner;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_i = 1'b0;
   logic       edge_pol_i = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_sel = 1'b0;
   logic [7:0] rd_data;
   logic       clr_i = 1'b0;
   logic       irq_flag_o;
   logic       trig_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   extint_conditioner dut (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .edge_pol_i(edge_pol_i),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
      .rd_data(rd_data), .clr_i(clr_i), .irq_flag_o(irq_flag_o), .trig_o(trig_o)
   );

   // behavioural reference
   int m_s1, m_s2, m_prev, m_filt, m_last, m_run, m_cnt, m_flag;
   int m_en, m_both, m_fsel;

   function automatic int m_lvl();
      return (m_fsel == 0) ? m_s2 : m_filt;
   endfunction

   function automatic int m_qual(int lv, int pv, int pol);
      if (m_en == 0) return 0;
      if (m_both != 0) return (lv != pv) ? 1 : 0;
      if (pol != 0) return (lv == 1 && pv == 0) ? 1 : 0;
      return (lv == 0 && pv == 1) ? 1 : 0;
   endfunction

   task automatic m_reset();
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_filt = 0; m_last = 0; m_run = 3;
      m_cnt = 0; m_flag = 0; m_en = 0; m_both = 0; m_fsel = 0;
   endtask

   initial m_reset();

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) m_reset();
      else begin
         int lv, q, mset, samp;
         lv = m_lvl();
         q = m_qual(lv, m_prev, int'(edge_pol_i));
         mset = (wr_en && !wr_sel && wr_data[0] && (int'(wr_data[1]) != m_both)) ? 1 : 0;
         if (q != 0 || mset != 0) m_flag = 1;
         else if (clr_i) m_flag = 0;
         samp = (m_fsel <= 1) || (m_fsel == 2 && (m_cnt % 8) == 7) ||
                (m_fsel == 3 && m_cnt == 31);
         if (samp) begin
            if (m_s2 == m_last) begin
               if (m_run < 3) m_run++;
            end else m_run = 1;
            m_last = m_s2;
            if (m_run >= 3) m_filt = m_s2;
         end
         m_cnt = (m_cnt + 1) % 32;
         m_prev = lv;
         m_s2 = m_s1;
         m_s1 = int'(pin_i);
         if (wr_en && !wr_sel) begin m_en = int'(wr_data[0]); m_both = int'(wr_data[1]); end
         if (wr_en && wr_sel) m_fsel = int'(wr_data[1:0]);
      end
   end

   task automatic check(int act, int exp, string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int exp_rd;
         exp_rd = rd_sel ? m_fsel : (m_both * 2 + m_en);
         check(int'(irq_flag_o), m_flag, "R6 flag vs model");
         check(int'(trig_o), m_qual(m_lvl(), m_prev, int'(edge_pol_i)), "R8 trig vs model");
         check(int'(rd_data), exp_rd, "R9 readback vs model");
      end
   end

   task automatic tick(int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   task automatic wr(bit sel, logic [7:0] d);
      @(posedge clk); #1 wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(posedge clk); #1 wr_en = 1'b0;
   endtask

   task automatic clr();
      @(posedge clk); #1 clr_i = 1'b1;
      @(posedge clk); #1 clr_i = 1'b0;
   endtask

   task automatic pulse(int width, int settle);
      @(posedge clk); #1 pin_i = 1'b1;
      tick(width);
      pin_i = 1'b0;
      tick(settle);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R9 reset state
      rd_sel = 1'b0; #1 check(int'(rd_data), 0, "R9 control after reset");
      rd_sel = 1'b1; #1 check(int'(rd_data), 0, "R9 filter after reset");
      check(int'(irq_flag_o), 0, "R6 flag after reset");
      // R9 reserved bits
      wr(1'b0, 8'hFD);
      rd_sel = 1'b0; #1 check(int'(rd_data), 1, "R9 control reserved bits");
      wr(1'b1, 8'hFC);
      rd_sel = 1'b1; #1 check(int'(rd_data), 0, "R9 filter reserved bits");
      rd_sel = 1'b0;
      // R2 falling only
      @(posedge clk); #1 pin_i = 1'b1; tick(10);
      check(int'(irq_flag_o), 0, "R2 rising ignored with pol 0");
      pin_i = 1'b0; tick(10);
      check(int'(irq_flag_o), 1, "R2 falling edge with pol 0");
      clr(); tick(1);
      check(int'(irq_flag_o), 0, "R6 clear strobe");
      // R2 rising only
      edge_pol_i = 1'b1;
      pin_i = 1'b1; tick(10);
      check(int'(irq_flag_o), 1, "R2 rising edge with pol 1");
      clr();
      pin_i = 1'b0; tick(10);
      check(int'(irq_flag_o), 0, "R2 falling ignored with pol 1");
      edge_pol_i = 1'b0;
      // R4 bypass passes a one-cycle pulse
      pulse(1, 10);
      check(int'(irq_flag_o), 1, "R4 bypass one-cycle pulse");
      clr();
      // R4/R5 every-clock sampling
      wr(1'b1, 8'h01); tick(5);
      pulse(2, 10);
      check(int'(irq_flag_o), 0, "R5 two-cycle glitch at f1");
      pulse(10, 10);
      check(int'(irq_flag_o), 1, "R4 long pulse at f1");
      clr();
      // divide by 8
      wr(1'b1, 8'h02); tick(5);
      pulse(16, 40);
      check(int'(irq_flag_o), 0, "R5 16-cycle glitch at f1/8");
      pulse(60, 40);
      check(int'(irq_flag_o), 1, "R4 long pulse at f1/8");
      clr();
      // divide by 32
      wr(1'b1, 8'h03); tick(5);
      pulse(64, 140);
      check(int'(irq_flag_o), 0, "R5 64-cycle glitch at f1/32");
      pulse(200, 140);
      check(int'(irq_flag_o), 1, "R4 long pulse at f1/32");
      clr();
      wr(1'b1, 8'h00); tick(5);
      // R7 switching to both edges sets the flag
      wr(1'b0, 8'h03); tick(1);
      check(int'(irq_flag_o), 1, "R7 mode change sets flag");
      clr(); tick(1);
      // R3 both edges
      pin_i = 1'b1; tick(8);
      check(int'(irq_flag_o), 1, "R3 rising in both-edges mode");
      clr();
      pin_i = 1'b0; tick(8);
      check(int'(irq_flag_o), 1, "R3 falling in both-edges mode");
      // R6 clear held across an edge: the set wins, then the clear
      @(posedge clk); #1 clr_i = 1'b1; pin_i = 1'b1;
      tick(8); clr_i = 1'b0; tick(1);
      check(int'(irq_flag_o), 0, "R6 clear after set-wins cycle");
      pin_i = 1'b0; tick(8); clr();
      // R7 same-value write and disabled write
      wr(1'b0, 8'h03); tick(1);
      check(int'(irq_flag_o), 0, "R7 unchanged mode bit no set");
      wr(1'b0, 8'h01); tick(1);
      check(int'(irq_flag_o), 1, "R7 back to single edge sets flag");
      clr();
      wr(1'b0, 8'h02); tick(1);
      check(int'(irq_flag_o), 0, "R7 change with enable 0 no set");
      // R1 disabled input
      pulse(5, 8); pulse(5, 8);
      check(int'(irq_flag_o), 0, "R1 disabled pin ignored");
      // R10 latency, single falling, bypass
      wr(1'b0, 8'h01); clr();
      pin_i = 1'b1; tick(8);
      pin_i = 1'b0;
      @(posedge clk); #2 check(int'(trig_o), 0, "R10 no trig after one edge");
      @(posedge clk); #2 check(int'(trig_o), 1, "R10 trig after two edges");
      tick(5);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule